// File: doc/BRIEF.md
# Multi-Channel Burst Tag Tracker

This block issues and tracks outstanding memory bursts for a set of DMA channels, each of which has a transmit requester and a receive requester. A requester holds its request line high while it wants to send a burst. The block picks one eligible requester per cycle with a rotating-priority arbiter. It chooses a free burst slot for that requester and places a command on the command channel. The command carries a tag made of the channel number, a receive flag and the slot index.

Responses may come back in any order. Each one carries the tag back. The block decodes the tag to find the requester and slot, frees that slot, and sends the requester a one-cycle completion pulse. A requester may have at most four bursts in flight, and is held off while all four of its slots are busy. A response that names an idle slot, or a channel that does not exist, sets a sticky protocol error flag. Data movement and address generation are handled outside this block.

Top module: `burst_tag_tracker`

## Requirements
- R1: After reset all slots are idle, `cmd_valid`, `done_pulse` and `proto_err` are 0, and the first burst of any requester uses slot 0.
- R2: Requester index r < NUM_CH is the transmit side of channel r, and r >= NUM_CH is the receive side of channel r-NUM_CH. A command carries the channel in `cmd_srcid` and the receive flag (1 = receive) in `cmd_trdid[2]`.
- R3: An issued burst takes the lowest-numbered idle slot of its requester, and that slot number is sent in `cmd_trdid[1:0]`.
- R4: A requester is eligible only while its request is high and fewer than 4 of its slots are busy. `cmd_valid` is high exactly when some requester is eligible.
- R5: At most one requester is granted per cycle. The search starts at the requester after the last one granted, wrapping at 2*NUM_CH (requester 0 after reset).
- R6: A burst is issued and `req_grant` pulses in the same cycle only when `cmd_valid` and `cmd_ready` are both high. Otherwise nothing is issued and the arbiter keeps its position.
- R7: A response naming a busy slot frees it in the same cycle. It raises `done_pulse` for that requester for exactly the next cycle, in whatever order responses arrive.
- R8: A response naming an idle slot, or a channel number >= NUM_CH, frees nothing, raises no done pulse, and sets `proto_err` from the next cycle until reset.
- R9: `cmd_len` always equals 2**BURST_LOG2 bytes. The default is 64, the largest burst allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2*NUM_CH | Per-requester burst request, held until granted |
| req_grant | output | 2*NUM_CH | One-cycle pulse when the requester's burst is issued |
| done_pulse | output | 2*NUM_CH | One-cycle completion pulse per requester |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Command accepted by the memory side |
| cmd_srcid | output | CH_W | Channel number of the command |
| cmd_trdid | output | 3 | {receive flag, slot index} |
| cmd_len | output | BURST_LOG2+1 | Burst length in bytes |
| rsp_valid | input | 1 | Response present |
| rsp_srcid | input | CH_W | Channel number returned with the response |
| rsp_trdid | input | 3 | {receive flag, slot index} returned with the response |
| proto_err | output | 1 | Sticky flag for a response naming an idle slot or an unknown channel |

## Verification
A directed run first fills one requester's four slots and checks that it is then held off. It then frees a middle slot and checks that the next burst reuses exactly that slot, which separates lowest-free allocation from round-robin slot use. Several requesters raised together with `cmd_ready` toggling show rotating priority apart from fixed priority, and show a stalled handshake apart from an issue. Long random mixes of requests and out-of-order responses to busy slots compare every tag, grant and done pulse against a reference model. A final response to an idle slot must set the sticky error and produce no done pulse.

// File: rtl/burst_tag_pkg.sv
package burst_tag_pkg;
    parameter int NUM_CH     = 8;
    parameter int BURST_LOG2 = 6;

    localparam int SLOTS       = 4;
    localparam int SLOT_W      = 2;
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NREQ        = 2 * NUM_CH;
    localparam int REQ_W       = $clog2(NREQ);
    localparam int LEN_W       = BURST_LOG2 + 1;
    localparam int BURST_BYTES = 1 << BURST_LOG2;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic              is_rx;
        logic [SLOT_W-1:0] slot;
    } burst_tag_t;

    function automatic burst_tag_t make_tag(input logic [REQ_W-1:0] req,
                                            input logic [SLOT_W-1:0] slot);
        burst_tag_t t;
        t.is_rx = (int'(req) >= NUM_CH);
        t.ch    = CH_W'(t.is_rx ? int'(req) - NUM_CH : int'(req));
        t.slot  = slot;
        return t;
    endfunction

    function automatic int tag_req(input burst_tag_t t);
        return (t.is_rx ? NUM_CH : 0) + int'(t.ch);
    endfunction
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter
    import burst_tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  eligible,
    input  logic             advance,
    output logic             any,
    output logic [REQ_W-1:0] winner
);
    logic [REQ_W-1:0] ptr;

    always_comb begin
        int idx;
        any    = 1'b0;
        winner = '0;
        for (int k = 0; k < NREQ; k++) begin
            idx = (int'(ptr) + k) % NREQ;
            if (!any && eligible[idx]) begin
                any    = 1'b1;
                winner = REQ_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance)
            ptr <= (int'(winner) == NREQ - 1) ? '0 : winner + 1'b1;
    end

    // R6: the arbiter only advances on a real winner
    assert_adv_has_winner_R6: assert property (@(posedge clk) disable iff (rst)
        advance |-> any);
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
    import burst_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              full,
    output logic [SLOT_W-1:0] free_slot,
    output logic              done,
    output logic              bad_rel
);
    logic [SLOTS-1:0] busy;
    logic             rel_ok;

    assign full    = &busy;
    assign rel_ok  = rel_valid && busy[rel_slot];
    assign bad_rel = rel_valid && !busy[rel_slot];

    always_comb begin
        free_slot = '0;
        for (int s = SLOTS - 1; s >= 0; s--)
            if (!busy[s]) free_slot = SLOT_W'(s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            done <= 1'b0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (issue && free_slot == SLOT_W'(s))
                    busy[s] <= 1'b1;
                else if (rel_ok && rel_slot == SLOT_W'(s))
                    busy[s] <= 1'b0;
            end
            done <= rel_ok;
        end
    end

    // R4: never issue into a requester with no idle slot
    assert_no_issue_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        issue |-> !full);
    // R7: a freed slot is idle in the following cycle
    assert_slot_freed_R7: assert property (@(posedge clk) disable iff (rst)
        (rel_ok && !issue) |=> !busy[$past(rel_slot)]);
endmodule

// File: rtl/burst_tag_tracker.sv
module burst_tag_tracker
    import burst_tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  req_valid,
    output logic [NREQ-1:0]  req_grant,
    output logic [NREQ-1:0]  done_pulse,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CH_W-1:0]  cmd_srcid,
    output logic [2:0]       cmd_trdid,
    output logic [LEN_W-1:0] cmd_len,
    input  logic             rsp_valid,
    input  logic [CH_W-1:0]  rsp_srcid,
    input  logic [2:0]       rsp_trdid,
    output logic             proto_err
);
    logic [NREQ-1:0]   full, bad_rel, rel_valid, eligible;
    logic [SLOT_W-1:0] free_slot [NREQ];
    logic              any, issue, rsp_in_range;
    logic [REQ_W-1:0]  winner;
    burst_tag_t        cmd_tag, rsp_tag;
    int                rsp_req;

    assign eligible = req_valid & ~full;
    assign issue    = any && cmd_ready;

    rr_arbiter u_arb (
        .clk(clk), .rst(rst), .eligible(eligible), .advance(issue),
        .any(any), .winner(winner)
    );

    assign rsp_tag      = {rsp_srcid, rsp_trdid};
    assign rsp_in_range = int'(rsp_srcid) < NUM_CH;
    assign rsp_req      = tag_req(rsp_tag);

    generate
        for (genvar r = 0; r < NREQ; r++) begin : g_req
            assign rel_valid[r] = rsp_valid && rsp_in_range && (rsp_req == r);
            slot_tracker u_slots (
                .clk(clk), .rst(rst),
                .issue(issue && winner == REQ_W'(r)),
                .rel_valid(rel_valid[r]), .rel_slot(rsp_tag.slot),
                .full(full[r]), .free_slot(free_slot[r]),
                .done(done_pulse[r]), .bad_rel(bad_rel[r])
            );
            assign req_grant[r] = issue && winner == REQ_W'(r);
        end
    endgenerate

    assign cmd_tag   = make_tag(winner, free_slot[winner]);
    assign cmd_valid = any;
    assign cmd_srcid = cmd_tag.ch;
    assign cmd_trdid = {cmd_tag.is_rx, cmd_tag.slot};
    assign cmd_len   = LEN_W'(BURST_BYTES);

    always_ff @(posedge clk) begin
        if (rst)
            proto_err <= 1'b0;
        else if ((|bad_rel) || (rsp_valid && !rsp_in_range))
            proto_err <= 1'b1;
    end

    // R5: at most one grant per cycle
    assert_one_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant));
    // R4: grants only go to requesters that asked
    assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        (req_grant & ~req_valid) == '0);
    // R8: the error flag, once set, stays set
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
    // R6: no grant without acceptance
    assert_grant_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> req_grant == '0);
endmodule

// File: tb/tb_burst_tag_tracker.sv
module tb_burst_tag_tracker;
    import burst_tag_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic [NREQ-1:0]  req_valid, req_grant, done_pulse;
    logic             cmd_valid, cmd_ready, rsp_valid, proto_err;
    logic [CH_W-1:0]  cmd_srcid, rsp_srcid;
    logic [2:0]       cmd_trdid, rsp_trdid;
    logic [LEN_W-1:0] cmd_len;

    always #5 clk = ~clk;

    burst_tag_tracker dut (.*);

    int tests = 0, fails = 0;
    bit m_busy [NREQ][SLOTS];
    int m_ptr = 0;
    bit [NREQ-1:0] m_done = '0;
    bit m_err = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int busy_cnt(input int r);
        int c = 0;
        for (int s = 0; s < SLOTS; s++) c += m_busy[r][s];
        return c;
    endfunction

    function automatic int low_free(input int r);
        for (int s = 0; s < SLOTS; s++) if (!m_busy[r][s]) return s;
        return -1;
    endfunction

    function automatic int pick(input logic [NREQ-1:0] rv);
        for (int k = 0; k < NREQ; k++) begin
            int idx = (m_ptr + k) % NREQ;
            if (rv[idx] && busy_cnt(idx) < SLOTS) return idx;
        end
        return -1;
    endfunction

    // one cycle: drive at negedge, check combinational and registered outputs, update model
    task automatic step(input logic [NREQ-1:0] rv, input bit rdy,
                        input bit rsp, input int rr, input int rs);
        int w, s;
        logic [NREQ-1:0] g_exp;
        @(negedge clk);
        req_valid = rv;
        cmd_ready = rdy;
        rsp_valid = rsp;
        rsp_srcid = CH_W'(rr % NUM_CH);
        rsp_trdid = {rr >= NUM_CH, 2'(rs)};
        #1;
        w = pick(rv);
        chk(cmd_valid == (w >= 0), "R4 cmd_valid", cmd_valid, w >= 0);
        chk(cmd_len == BURST_BYTES, "R9 cmd_len", cmd_len, BURST_BYTES);
        chk(done_pulse == m_done, "R7 done_pulse", done_pulse, m_done);
        chk(proto_err == m_err, "R8 proto_err", proto_err, m_err);
        g_exp = '0;
        if (w >= 0) begin
            s = low_free(w);
            chk(cmd_srcid == w % NUM_CH, "R2 cmd_srcid", cmd_srcid, w % NUM_CH);
            chk(cmd_trdid[2] == (w >= NUM_CH), "R2 rx flag", cmd_trdid[2], w >= NUM_CH);
            chk(cmd_trdid[1:0] == s, "R3 slot", cmd_trdid[1:0], s);
            if (rdy) g_exp[w] = 1'b1;
        end
        chk(req_grant == g_exp, rdy ? "R5 req_grant" : "R6 req_grant", req_grant, g_exp);
        m_done = '0;
        if (rsp) begin
            if (rr < NREQ && m_busy[rr][rs]) begin
                m_busy[rr][rs] = 0;
                m_done[rr] = 1'b1;
            end else m_err = 1;
        end
        if (w >= 0 && rdy) begin
            m_busy[w][s] = 1;
            m_ptr = (w + 1) % NREQ;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; req_valid = '0; cmd_ready = 0; rsp_valid = 0; rsp_srcid = '0; rsp_trdid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1: reset state
        chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
        chk(done_pulse == 0, "R1 done_pulse", done_pulse, 0);
        chk(proto_err == 0, "R1 proto_err", proto_err, 0);
        // R1/R3/R4: fill requester 0, then held off
        for (int i = 0; i < 5; i++) step(NREQ'(1), 1, 0, 0, 0);
        // R6: stall with ready low
        step(NREQ'(2), 0, 0, 0, 0);
        // R7: free middle slot out of order, then reuse it (R3)
        step('0, 1, 1, 0, 2);
        step(NREQ'(1), 1, 0, 0, 0);
        step('0, 1, 1, 0, 3);
        step('0, 1, 1, 0, 0);
        // R5: rotating priority across several requesters
        for (int i = 0; i < 6; i++) step(NREQ'(32'h0000_8421), 1, 0, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [NREQ-1:0] rv = NREQ'($urandom) & NREQ'($urandom);
            int rr = $urandom % NREQ;
            int rs = $urandom % SLOTS;
            bit rsp = m_busy[rr][rs] && ($urandom % 4 != 0);
            step(rv, ($urandom % 4) != 0, rsp, rr, rs);
        end
        // R8: response to an idle slot, then sticky
        begin
            int rr = -1, rs = 0;
            for (int r = 0; r < NREQ; r++)
                for (int s = 0; s < SLOTS; s++)
                    if (rr < 0 && !m_busy[r][s]) begin rr = r; rs = s; end
            if (rr >= 0) step('0, 0, 1, rr, rs);
        end
        for (int i = 0; i < 4; i++) step('0, 0, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule